// File: doc/BRIEF.md
# Supply Fault Supervision Sequencer

This block sequences the enable of an external pass switch that sits between a raw supply input and protected circuitry. It watches two comparator results, one saying the input is above the undervoltage threshold and one saying it is above the overvoltage threshold, plus an active-low enable. After the input has been continuously healthy for a programmable power-good delay, the block performs an overvoltage check and turns the switch on. It keeps the active-low fault flag asserted for a further programmable blanking period, so that downstream logic only sees a clean indication once the switched rail has settled.

Any overvoltage or undervoltage condition drops the switch and asserts the flag without waiting on a timer. A disable request also drops the switch but never makes a fault look cleared. Every way out of normal operation leads back to the idle state, and the whole delay and blanking sequence then restarts from zero. A parameter selects the flag pin style. In push-pull style the flag level is driven directly and the enable input is ignored. In open-drain style the block produces a constant-low data value and an output-enable that is active only while the flag is asserted.

Top module: `supply_guard_seq`

## Requirements
- R1: After reset the gate enable (`gateOn`) is 0 and the flag is asserted.
- R2: Once the input is healthy (above undervoltage, not above overvoltage, enabled), `gateOn` rises exactly START_CYCLES+3 clock edges after the input change. That count is two synchronizer stages, START_CYCLES of power-good delay and one overvoltage-check cycle. Before then the flag stays asserted.
- R3: After `gateOn` rises, the flag stays asserted for exactly BLANK_CYCLES further edges and then deasserts, while `gateOn` stays 1.
- R4: A rising overvoltage input drops `gateOn` to 0 and asserts the flag two edges later (synchronizer latency only), in any state.
- R5: A falling undervoltage input drops `gateOn` to 0 and asserts the flag two edges later, in any state.
- R6: In open-drain style, `enN`=1 forces `gateOn` to 0 and asserts the flag. Returning `enN` to 0 repeats the full R2/R3 sequence.
- R7: `enN` cannot clear a fault. While overvoltage is present, the flag stays asserted and `gateOn` stays 0 whatever the value of `enN`.
- R8: If a fault interrupts the power-good delay, the partial count is discarded. After the fault clears, the full START_CYCLES+3 edges pass again before `gateOn` rises.
- R9: Open-drain style (OPEN_DRAIN=1): `flagOut` is always 0 and `flagOe` is 1 exactly when the flag is asserted.
- R10: Push-pull style (OPEN_DRAIN=0): `flagOe` is always 1, `flagOut` is 0 when the flag is asserted and 1 when it is deasserted, and `enN` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aboveUv | input | 1 | Comparator: input above undervoltage threshold (asynchronous) |
| aboveOv | input | 1 | Comparator: input above overvoltage threshold (asynchronous) |
| enN | input | 1 | Active-low enable; used only in open-drain style |
| gateOn | output | 1 | Turns the external pass switch on when 1 |
| flagOut | output | 1 | Flag pin data value (active-low flag) |
| flagOe | output | 1 | Flag pin output enable |

## Verification
Two instances run side by side, one in open-drain style and one in push-pull style, with short delay parameters. The main sequence is exercised from reset, after an overvoltage fault, after an undervoltage drop and after a disable. Each run has its gate-on and flag-release edges timed to the exact cycle, which separates an off-by-one in either timer from a correct count. A healthy input cut off midway through the power-good delay shows whether partial counts are kept. Asserting overvoltage and enable together, then releasing only the enable, shows that the enable cannot mask a fault. The push-pull instance, left with its enable input high, shows that the enable is ignored in that style.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_OVCHECK = 2'd1,
    ST_STARTUP = 2'd2,
    ST_ON      = 2'd3
  } seqState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic selBlank;
  } tmrStrobe_t;

endpackage

// File: rtl/sgs_sync.sv
module sgs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;

endmodule

// File: rtl/sgs_timer.sv
module sgs_timer
  import sgs_pkg::*;
#(
  parameter int START_CYCLES = 50000,
  parameter int BLANK_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strobe,
  output logic       limitHit
);

  localparam int MAX_CYCLES = (START_CYCLES > BLANK_CYCLES) ? START_CYCLES : BLANK_CYCLES;
  localparam int CW = $clog2(MAX_CYCLES + 1);
  localparam logic [CW-1:0] START_LAST = CW'(START_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYCLES - 1);

  logic [CW-1:0] count;
  logic [CW-1:0] lastVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntClr) begin
      count <= '0;
    end else if (strobe.cntInc) begin
      count <= count + 1'b1;
    end
  end

  assign lastVal  = strobe.selBlank ? BLANK_LAST : START_LAST;
  assign limitHit = (count == lastVal);

  // R8: a clear strobe always leaves the count at zero, no partial value kept
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (count == '0));

  // R2, R3: the count never runs beyond the longer of the two windows
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(MAX_CYCLES));

endmodule

// File: rtl/sgs_ctrl.sv
module sgs_ctrl
  import sgs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvOk,
  input  logic       ovHi,
  input  logic       disReq,
  input  logic       limitHit,
  output tmrStrobe_t strobe,
  output logic       gateOn,
  output logic       flagAsserted
);

  seqState_t state;
  seqState_t stateNext;
  logic      healthy;

  assign healthy = uvOk && !ovHi && !disReq;

  always_comb begin
    stateNext       = state;
    strobe.cntClr   = 1'b1;
    strobe.cntInc   = 1'b0;
    strobe.selBlank = 1'b0;
    unique case (state)
      ST_STANDBY: begin
        if (healthy) begin
          if (limitHit) begin
            stateNext = ST_OVCHECK;
          end else begin
            strobe.cntClr = 1'b0;
            strobe.cntInc = 1'b1;
          end
        end
      end
      ST_OVCHECK: begin
        stateNext = healthy ? ST_STARTUP : ST_STANDBY;
      end
      ST_STARTUP: begin
        strobe.selBlank = 1'b1;
        if (!healthy) begin
          stateNext = ST_STANDBY;
        end else if (limitHit) begin
          stateNext = ST_ON;
        end else begin
          strobe.cntClr = 1'b0;
          strobe.cntInc = 1'b1;
        end
      end
      ST_ON: begin
        if (!healthy) stateNext = ST_STANDBY;
      end
      default: stateNext = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STANDBY;
    else       state <= stateNext;
  end

  // faults act on the outputs without waiting for a state change
  assign gateOn       = healthy && (state == ST_STARTUP || state == ST_ON);
  assign flagAsserted = !(healthy && state == ST_ON);

  // R3: the flag is never released while the gate is off
  a_r3_flag_when_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |-> flagAsserted);

  // R2: startup is entered only through the overvoltage check
  a_r2_startup_via_check: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_STARTUP) |-> $past(state == ST_OVCHECK));

  // R3: the on state is reached only after blanking in startup
  a_r3_on_via_startup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ON) |-> $past(state == ST_STARTUP));

  // R4: a synchronized overvoltage keeps the gate off
  a_r4_ov_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    ovHi |-> (!gateOn && flagAsserted));

  // R5: a synchronized undervoltage keeps the gate off
  a_r5_uv_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !uvOk |-> (!gateOn && flagAsserted));

  // R6, R7: disable forces the gate off and never clears the flag
  a_r6_disable_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    disReq |-> (!gateOn && flagAsserted));

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import sgs_pkg::*;
#(
  parameter int START_CYCLES = 50000,
  parameter int BLANK_CYCLES = 50000,
  parameter bit OPEN_DRAIN   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic aboveUv,
  input  logic aboveOv,
  input  logic enN,
  output logic gateOn,
  output logic flagOut,
  output logic flagOe
);

  logic [2:0] rawIn;
  logic [2:0] syncIn;
  logic       disRaw;
  tmrStrobe_t strobe;
  logic       limitHit;
  logic       flagAsserted;

  // enable exists only in open-drain style; otherwise held at enabled
  assign disRaw = OPEN_DRAIN ? enN : 1'b0;
  assign rawIn  = {disRaw, aboveOv, aboveUv};

  sgs_sync #(.WIDTH(3)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  sgs_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .uvOk         (syncIn[0]),
    .ovHi         (syncIn[1]),
    .disReq       (syncIn[2]),
    .limitHit     (limitHit),
    .strobe       (strobe),
    .gateOn       (gateOn),
    .flagAsserted (flagAsserted)
  );

  sgs_timer #(
    .START_CYCLES (START_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .limitHit (limitHit)
  );

  generate
    if (OPEN_DRAIN) begin : g_od
      assign flagOut = 1'b0;
      assign flagOe  = flagAsserted;
      // R9: the pin is only ever pulled low, never driven high
      a_r9_od_low_only: assert property (@(posedge clk) disable iff (!rstN)
        flagOe |-> !flagOut);
    end else begin : g_pp
      assign flagOut = !flagAsserted;
      assign flagOe  = 1'b1;
      // R10: push-pull keeps the pin driven at all times
      a_r10_pp_driven: assert property (@(posedge clk) disable iff (!rstN)
        flagOe);
    end
  endgenerate

endmodule

// File: tb/supply_guard_seq_tb.sv
module supply_guard_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int S = 10;
  localparam int B = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveUv = 1'b0;
  logic aboveOv = 1'b0;
  logic enOd = 1'b0;
  logic enPp = 1'b1;
  logic gateOd, flagOutOd, flagOeOd;
  logic gatePp, flagOutPp, flagOePp;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_guard_seq #(.START_CYCLES(S), .BLANK_CYCLES(B), .OPEN_DRAIN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .aboveUv(aboveUv), .aboveOv(aboveOv), .enN(enOd),
    .gateOn(gateOd), .flagOut(flagOutOd), .flagOe(flagOeOd));

  supply_guard_seq #(.START_CYCLES(S), .BLANK_CYCLES(B), .OPEN_DRAIN(1'b0)) u_pp (
    .clk(clk), .rstN(rstN), .aboveUv(aboveUv), .aboveOv(aboveOv), .enN(enPp),
    .gateOn(gatePp), .flagOut(flagOutPp), .flagOe(flagOePp));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // flag asserted as seen at the pins
  function automatic int odFlag();
    return int'(flagOeOd);
  endfunction
  function automatic int ppFlag();
    return int'(!flagOutPp);
  endfunction

  // called right after an input change made at a falling edge
  task automatic expectSequence(input string tag, input bit withOd, input bit withPp);
    edges(S + 2);
    if (withOd) check({tag, " R2 od gate early"}, gateOd, 0);
    if (withPp) check({tag, " R2 pp gate early"}, gatePp, 0);
    edges(1);
    if (withOd) begin
      check({tag, " R2 od gate on"}, gateOd, 1);
      check({tag, " R3 od flag held"}, odFlag(), 1);
    end
    if (withPp) check({tag, " R2 pp gate on"}, gatePp, 1);
    edges(B - 1);
    if (withOd) check({tag, " R3 od flag still held"}, odFlag(), 1);
    if (withPp) check({tag, " R3 pp flag still held"}, ppFlag(), 1);
    edges(1);
    if (withOd) begin
      check({tag, " R3 od flag released"}, odFlag(), 0);
      check({tag, " R3 od gate stays"}, gateOd, 1);
    end
    if (withPp) check({tag, " R3 pp flag released"}, ppFlag(), 0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 od gate off", gateOd, 0);
    check("R1 od flag asserted", odFlag(), 1);
    check("R1 pp flag asserted", ppFlag(), 1);
    @(negedge clk); rstN = 1'b1;
    edges(3);
    check("R1 od gate idle", gateOd, 0);
  endtask

  task automatic t_bringup();
    @(negedge clk); aboveUv = 1'b1; aboveOv = 1'b0; enOd = 1'b0;
    expectSequence("bringup", 1'b1, 1'b1);
    check("R10 pp enN ignored, gate on", gatePp, 1);
    check("R10 pp flagOut high", flagOutPp, 1);
    check("R10 pp flagOe", flagOePp, 1);
    check("R9 od flagOut low", flagOutOd, 0);
    check("R9 od flagOe off when released", flagOeOd, 0);
  endtask

  task automatic t_ov();
    @(negedge clk); aboveOv = 1'b1;
    edges(2);
    check("R4 od gate off", gateOd, 0);
    check("R4 od flag", odFlag(), 1);
    check("R4 pp gate off", gatePp, 0);
    check("R10 pp flagOut low", flagOutPp, 0);
    check("R9 od flagOe on", flagOeOd, 1);
    check("R9 od flagOut", flagOutOd, 0);
    edges(S + B + 5);
    check("R4 od gate held off", gateOd, 0);
    @(negedge clk); aboveOv = 1'b0;
    expectSequence("after ov R4", 1'b1, 1'b1);
  endtask

  task automatic t_uv();
    @(negedge clk); aboveUv = 1'b0;
    edges(2);
    check("R5 od gate off", gateOd, 0);
    check("R5 od flag", odFlag(), 1);
    check("R5 pp gate off", gatePp, 0);
    check("R5 pp flag", ppFlag(), 1);
    @(negedge clk); aboveUv = 1'b1;
    expectSequence("after uv R5", 1'b1, 1'b1);
  endtask

  task automatic t_disable();
    @(negedge clk); enOd = 1'b1;
    edges(2);
    check("R6 od gate off", gateOd, 0);
    check("R6 od flag", odFlag(), 1);
    check("R10 pp unaffected", gatePp, 1);
    edges(S + B + 5);
    check("R6 od stays off", gateOd, 0);
    @(negedge clk); enOd = 1'b0;
    expectSequence("after disable R6", 1'b1, 1'b0);
  endtask

  task automatic t_en_no_clear();
    @(negedge clk); aboveOv = 1'b1; enOd = 1'b1;
    edges(3);
    check("R7 od flag with ov and disable", odFlag(), 1);
    check("R7 od gate off", gateOd, 0);
    @(negedge clk); enOd = 1'b0;
    edges(S + B + 5);
    check("R7 od flag after enable", odFlag(), 1);
    check("R7 od gate after enable", gateOd, 0);
    @(negedge clk); aboveOv = 1'b0;
    expectSequence("after fault R7", 1'b1, 1'b1);
  endtask

  task automatic t_restart();
    @(negedge clk); aboveUv = 1'b0;
    edges(4);
    @(negedge clk); aboveUv = 1'b1;
    edges(2 + S/2);
    check("R8 od gate off mid delay", gateOd, 0);
    @(negedge clk); aboveUv = 1'b0;
    edges(4);
    @(negedge clk); aboveUv = 1'b1;
    expectSequence("restart R8", 1'b1, 1'b1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_bringup();
    t_ov();
    t_uv();
    t_disable();
    t_en_no_clear();
    t_restart();
    finish();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule